// File: doc/BRIEF.md
# Bus-Attached Shift Register

This block is a register of `WIDTH` flip-flops (eight by default) that hangs on a shared bidirectional data bus. Two select inputs pick one of four operating modes: keep the stored word, put it onto the bus, capture the word on the bus, or move it one place toward the top bit while a single serial input pin fills the bottom bit. Every change to the stored word happens on the rising clock edge.

The bus is modelled as three separate signals: an incoming word, an outgoing word and an output-enable that stands in for the tri-state driver. The driver is switched on only in the read mode; in every other mode the bus is released. While shifting, the bit leaving the top of the chain is presented on a serial output pin, so several of these registers can be chained bit-serially. A synchronous active-high reset clears the word to zero.

Top module: `bus_shift_reg`

## Requirements
- R1: With `rst` high at a rising clock edge the stored word becomes all zeros, whatever the select inputs are.
- R2: With `{sel0,sel1}` = 2'b00 (hold) the stored word does not change across clock edges, whatever `bus_in` and `ser_in` carry.
- R3: With `{sel0,sel1}` = 2'b01 (read) `bus_oe` is 1, `bus_out` equals the stored word in the same cycle, and the stored word does not change at the clock edge.
- R4: With `{sel0,sel1}` = 2'b11 (load) the stored word takes the value of `bus_in` at the rising clock edge.
- R5: With `{sel0,sel1}` = 2'b10 (shift) each rising edge moves every bit one place up (bit i takes bit i-1) and bit 0 takes `ser_in`.
- R6: In hold, shift and load modes `bus_oe` is 0 and `bus_out` is all zeros.
- R7: In shift mode `ser_out` equals the current top bit (bit `WIDTH`-1) of the stored word before the edge; in every other mode `ser_out` is 0.
- R8: `WIDTH` consecutive shifts replace the whole stored word with the serial bits, the first bit shifted in ending up in the top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to zero |
| sel0 | input | 1 | Mode select, upper bit of the mode code |
| sel1 | input | 1 | Mode select, lower bit of the mode code |
| ser_in | input | 1 | Serial data entering bit 0 in shift mode |
| bus_in | input | WIDTH | Word currently on the shared bus |
| bus_out | output | WIDTH | Word the block drives onto the bus (zero when not driving) |
| bus_oe | output | 1 | Bus driver enable, high only in read mode |
| ser_out | output | 1 | Top bit of the stored word during shift mode, else 0 |

## Verification
The bus driver enable, `bus_out` and `ser_out` are combinational in the mode and the stored word, so they are due in the same cycle the select inputs are applied; the effect of hold, load, shift and reset on the stored word is due one rising edge later and becomes visible at the ports only through a later read cycle. The driver task applies each cycle's inputs on the falling edge and queues the outputs a reference model predicts for that cycle before advancing the model across the coming rising edge. The monitor samples three nanoseconds after the same falling edge, well before the next rising edge, so every comparison sees the settled outputs of exactly the cycle that was queued.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   // Mode code is {sel0, sel1}.
   typedef enum logic [1:0] {
      BSR_HOLD  = 2'b00,
      BSR_READ  = 2'b01,
      BSR_SHIFT = 2'b10,
      BSR_LOAD  = 2'b11
   } bsr_mode_e;

endpackage

// File: rtl/bsr_mode_dec.sv
module bsr_mode_dec
   import bsr_pkg::*;
(
   input  logic      sel0,
   input  logic      sel1,
   output bsr_mode_e mode,
   output logic      drive_en,
   output logic      shift_en,
   output logic      load_en
);

   always_comb begin
      mode = bsr_mode_e'({sel0, sel1});
   end

   always_comb begin
      drive_en = 1'b0;
      shift_en = 1'b0;
      load_en  = 1'b0;
      unique case (mode)
         BSR_READ:  drive_en = 1'b1;
         BSR_SHIFT: shift_en = 1'b1;
         BSR_LOAD:  load_en  = 1'b1;
         default:   ;
      endcase
   end

endmodule

// File: rtl/bsr_reg_core.sv
module bsr_reg_core #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             shift_en,
   input  logic             load_en,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] q
);

   localparam int TOP = WIDTH - 1;

   logic [WIDTH-1:0] shift_src;
   logic [WIDTH-1:0] nxt;

   // Per-bit source for the shift path: bit 0 from the pin, others from below.
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == 0) begin : g_entry
            assign shift_src[i] = ser_in;
         end else begin : g_chain
            assign shift_src[i] = q[i-1];
         end

         always_comb begin
            if (load_en)       nxt[i] = bus_in[i];
            else if (shift_en) nxt[i] = shift_src[i];
            else               nxt[i] = q[i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end

   logic unused_top;
   assign unused_top = q[TOP];

endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage #(
   parameter int WIDTH    = 8,
   parameter bit GATE_BUS = 1'b1
) (
   input  logic [WIDTH-1:0] q,
   input  logic             drive_en,
   input  logic             shift_en,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe,
   output logic             ser_out
);

   localparam int TOP = WIDTH - 1;

   assign bus_oe  = drive_en;
   assign ser_out = shift_en & q[TOP];

   generate
      if (GATE_BUS) begin : g_gated
         assign bus_out = drive_en ? q : '0;
      end else begin : g_masked
         assign bus_out = q & {WIDTH{drive_en}};
      end
   endgenerate

endmodule

// File: rtl/bus_shift_reg.sv
module bus_shift_reg
   import bsr_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter bit GATE_BUS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel0,
   input  logic             sel1,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe,
   output logic             ser_out
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bus_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   bsr_mode_e        mode;
   logic             drive_en;
   logic             shift_en;
   logic             load_en;
   logic [WIDTH-1:0] state_q;

   bsr_mode_dec u_dec (
      .sel0     (sel0),
      .sel1     (sel1),
      .mode     (mode),
      .drive_en (drive_en),
      .shift_en (shift_en),
      .load_en  (load_en)
   );

   bsr_reg_core #(.WIDTH(WIDTH)) u_core (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .load_en  (load_en),
      .ser_in   (ser_in),
      .bus_in   (bus_in),
      .q        (state_q)
   );

   bsr_out_stage #(.WIDTH(WIDTH), .GATE_BUS(GATE_BUS)) u_out (
      .q        (state_q),
      .drive_en (drive_en),
      .shift_en (shift_en),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe),
      .ser_out  (ser_out)
   );

   bsr_mode_e unused_mode;
   assign unused_mode = mode;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             sel0,
   input logic             sel1,
   input logic             ser_in,
   input logic [WIDTH-1:0] bus_in,
   input logic [WIDTH-1:0] bus_out,
   input logic             bus_oe,
   input logic             ser_out,
   input logic [WIDTH-1:0] q
);

   localparam int TOP = WIDTH - 1;

   logic is_hold, is_read, is_shift, is_load;
   assign is_hold  = !sel0 && !sel1;
   assign is_read  = !sel0 &&  sel1;
   assign is_shift =  sel0 && !sel1;
   assign is_load  =  sel0 &&  sel1;

   assert_hold_keeps_R2: assert property (@(posedge clk) disable iff (rst)
      is_hold |=> $stable(q));

   assert_read_drives_R3: assert property (@(posedge clk) disable iff (rst)
      is_read |-> (bus_oe && bus_out == q));

   assert_read_keeps_R3: assert property (@(posedge clk) disable iff (rst)
      is_read |=> $stable(q));

   assert_load_captures_R4: assert property (@(posedge clk) disable iff (rst)
      is_load |=> q == $past(bus_in));

   assert_shift_moves_R5: assert property (@(posedge clk) disable iff (rst)
      is_shift |=> q == {$past(q[TOP-1:0]), $past(ser_in)});

   assert_bus_released_R6: assert property (@(posedge clk) disable iff (rst)
      !is_read |-> (!bus_oe && bus_out == '0));

   assert_serial_out_R7: assert property (@(posedge clk) disable iff (rst)
      ser_out == (is_shift && q[TOP]));

endmodule

bind bus_shift_reg bsr_checker #(.WIDTH(WIDTH)) u_bsr_chk (
   .clk     (clk),
   .rst     (rst),
   .sel0    (sel0),
   .sel1    (sel1),
   .ser_in  (ser_in),
   .bus_in  (bus_in),
   .bus_out (bus_out),
   .bus_oe  (bus_oe),
   .ser_out (ser_out),
   .q       (state_q)
);

// File: tb/bus_shift_reg_test.sv
module bus_shift_reg_test;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         sel0 = 1'b0;
   logic         sel1 = 1'b0;
   logic         ser_in = 1'b0;
   logic [W-1:0] bus_in = '0;
   logic [W-1:0] bus_out;
   logic         bus_oe;
   logic         ser_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      logic         oe;
      logic [W-1:0] bus;
      logic         so;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   logic [W-1:0] model_q = '0;

   always #5 clk = ~clk;

   bus_shift_reg #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .sel0(sel0), .sel1(sel1), .ser_in(ser_in),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ser_out(ser_out)
   );

   // Driver: apply one cycle, queue the outputs due in it, advance the model.
   task automatic step(input logic s0, input logic s1, input logic si,
                       input logic [W-1:0] bi, input logic rs, input string tag);
      exp_t e;
      @(negedge clk);
      sel0 = s0; sel1 = s1; ser_in = si; bus_in = bi; rst = rs;
      e.oe  = (!s0 && s1);
      e.bus = e.oe ? model_q : '0;
      e.so  = (s0 && !s1) ? model_q[W-1] : 1'b0;
      e.tag = tag;
      sb.push_back(e);
      if (rs)              model_q = '0;
      else if (s0 && s1)   model_q = bi;
      else if (s0 && !s1)  model_q = {model_q[W-2:0], si};
   endtask

   task automatic do_read(input string tag);
      step(1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, tag);
   endtask

   // Monitor: compare each queued cycle well before the next rising edge.
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (bus_oe !== e.oe || bus_out !== e.bus || ser_out !== e.so) begin
               errors++;
               $display("FAIL %s: got oe=%b bus=%h so=%b, expected oe=%b bus=%h so=%b",
                        e.tag, bus_oe, bus_out, ser_out, e.oe, e.bus, e.so);
            end
         end
      end
   end

   initial begin
      logic [W-1:0] pat;
      // R1: reset clears the word even while load is selected
      step(1'b1, 1'b1, 1'b0, 8'h99, 1'b1, "R1 reset during load");
      do_read("R1 word zero after reset");
      // R4: load then read back
      step(1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, "R6 load releases bus");
      do_read("R4 load captured A5");
      // R2: hold with noisy bus and serial pin
      step(1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, "R6 hold releases bus");
      step(1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, "R2 hold");
      step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R2 hold");
      do_read("R2 hold kept A5");
      // R3: repeated reads leave the word intact
      do_read("R3 read again");
      do_read("R3 read third time");
      // R5/R7: single shifts, ser_out shows top bit before the edge
      step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, "R7 shift out top bit 1");
      do_read("R5 one shift gives 4B");
      step(1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, "R7 shift out top bit 0");
      do_read("R5 second shift gives 96");
      // R8: WIDTH shifts replace the whole word, first bit lands on top
      pat = 8'h3C;
      for (int i = W - 1; i >= 0; i--)
         step(1'b1, 1'b0, pat[i], 8'h00, 1'b0, "R7 serial out during fill");
      do_read("R8 eight shifts gave 3C");
      pat = 8'hC1;
      for (int i = W - 1; i >= 0; i--)
         step(1'b1, 1'b0, pat[i], 8'h5A, 1'b0, "R7 serial out during refill");
      do_read("R8 eight shifts gave C1");
      // R4/R6: load all ones then all zeros
      step(1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, "R6 load releases bus");
      do_read("R4 load captured FF");
      step(1'b1, 1'b1, 1'b1, 8'h00, 1'b0, "R6 load releases bus");
      do_read("R4 load captured 00");
      // R1: reset in the middle of activity
      step(1'b1, 1'b1, 1'b0, 8'h77, 1'b0, "R6 load releases bus");
      step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R1 reset during read");
      do_read("R1 word zero after second reset");
      @(negedge clk);
      @(negedge clk);
      #5;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule